// File: doc/BRIEF.md
# Tiled Scanout Address Generator

This block walks a framebuffer that is stored as independent 64 KB tiles, each 512 bytes wide and 128 lines tall, and produces the memory reads a display DMA engine needs to scan it out. Every tile is located through a table of 16-bit entries, each holding the tile's physical base address divided by 65536. The table itself sits at a 512-byte aligned address, given to the block as that address divided by 512. For each scan row the block reads the table entry of every tile column, then issues 64-byte burst reads for the row inside that tile. Returned pixel words go into an internal FIFO that feeds the display pipeline.

The frame is described by a count of full tiles across, the pixel width of an optional narrower right-hand tile, a depth code and the number of 512-byte rows to fetch. With one full tile across and a large row count, the walk covers 128 rows of one tile and then moves to the next table entry, so a linear buffer can be scanned. The DMA enable written by software takes effect only when a frame starts. A FIFO clear input empties the pixel FIFO for as long as it is held high.

Top module: `tile_scan_fetch`

## Requirements
- R1: While reset is held and after it is released, `dma_on`, `req_valid` and `pix_valid` are low.
- R2: `dma_on` takes the value of `dma_en` only when a frame starts; a change of `dma_en` alone does nothing, and no request is issued while `dma_on` is low.
- R3: A table read is a single-beat request (`req_len` = 1) at the 8-byte aligned word holding byte address `tbl_base`*512 + 2*idx; the entry is taken from the 16-bit lane idx mod 4 of the returned word, lane 0 being bits 15:0.
- R4: A data request has `req_len` = 8 (8 beats of 64 bits) at address entry*65536 + (row mod 128)*512 + k*64, where k counts the bursts within the tile segment from 0.
- R5: Rows are walked from 0 to `height`-1; within a row the tile columns go left to right, each as a table read followed by its bursts; the tile index is (row/128)*columns + column.
- R6: The right-hand tile exists when `rhs_pix` is non-zero and takes ceil(min(`rhs_pix` << s, 512)/64) bursts, with s = 0, 1, 2 for `depth` codes 0 (8 bpp), 1 (16 bpp) and 2 or 3 (32 bpp); a full tile takes 8 bursts.
- R7: A data request is made only while the FIFO (32 words) has at least 8 free words, so it never overflows and no data is lost when the sink stalls.
- R8: `pix_valid` is high whenever the FIFO holds data, and words leave in the order they were returned.
- R9: In a cycle with `fifo_clr` high the FIFO is emptied; a returned word or a pop in that same cycle is discarded, and `pix_valid` is low on the next cycle.
- R10: After the last burst of the last row no further request is made until the next frame start, and each frame begins at row 0, column 0; a frame with `height` 0 or no tile columns issues nothing.
- R11: A frame start that arrives while a request is outstanding is held until that request's data has all returned; the next request is then the table read for tile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 23 | Tile table address divided by 512 |
| tiles_whole | input | 6 | Number of full tiles across |
| rhs_pix | input | 9 | Pixel width of the right-hand partial tile, 0 for none |
| depth | input | 2 | Pixel depth code: 0 8 bpp, 1 16 bpp, 2/3 32 bpp |
| height | input | 12 | Number of 512-byte rows per frame |
| dma_en | input | 1 | Requested DMA enable |
| fifo_clr | input | 1 | Empties the pixel FIFO while high |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| dma_on | output | 1 | Effective DMA enable |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Request byte address |
| req_len | output | 4 | Request length in 64-bit beats |
| rsp_valid | input | 1 | Returned beat valid |
| rsp_data | input | 64 | Returned beat data |
| pix_valid | output | 1 | Pixel FIFO holds data |
| pix_ready | input | 1 | Display pipeline takes a word |
| pix_data | output | 64 | Oldest FIFO word |

## Verification
The FIFO clear, a returning data beat and a pop by the display side can all fall in one cycle. The bench holds the sink back until the FIFO has data, then raises the clear for one cycle in the middle of a burst while a beat is being delivered and the sink is ready. It judges that the FIFO is empty on the next cycle and that the following beat of the same burst is accepted once the clear drops. A frame start arriving in the middle of a burst is a second such meeting; there the bench checks that the burst finishes and the very next request is the table read of tile 0.

// File: rtl/tile_scan_fetch.sv
module tile_scan_fetch #(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int BEATS      = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int HW         = 12,
  parameter int TW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-10:0] tbl_base,
  input  logic [TW-1:0] tiles_whole,
  input  logic [8:0]    rhs_pix,
  input  logic [1:0]    depth,
  input  logic [HW-1:0] height,
  input  logic          dma_en,
  input  logic          fifo_clr,
  input  logic          frame_start,
  output logic          dma_on,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [$clog2(BEATS):0] req_len,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [DW-1:0] pix_data
);
  localparam int BB   = BEATS * DW / 8;
  localparam int BBS  = $clog2(BB);
  localparam int RB   = 512 / BB;
  localparam int BW   = $clog2(RB) + 1;
  localparam int LW   = $clog2(DW / 16);
  localparam int FW   = $clog2(FIFO_DEPTH);
  localparam int CW   = FW + 1;
  localparam int LENW = $clog2(BEATS) + 1;
  localparam int IW   = HW - 7 + TW + 1;

  typedef enum logic [2:0] {S_IDLE, S_TREQ, S_TWAIT, S_DREQ, S_DWAIT} st_t;
  st_t state;

  logic          pend;
  logic [HW-1:0] line;
  logic [TW:0]   tcol;
  logic [BW-1:0] bcnt;
  logic [LENW-1:0] bt;
  logic [15:0]   entry;
  logic [CW-1:0] count;
  logic [FW-1:0] wp, rp;
  logic [DW-1:0] mem [FIFO_DEPTH];

  // partial right-hand tile in bursts
  logic [1:0]    sh;
  logic [10:0]   rhs_bytes, rhs_cl;
  logic [BW-1:0] rhs_bursts, seg_bursts;
  logic [TW:0]   across;
  assign sh         = depth[1] ? 2'd2 : depth;
  assign rhs_bytes  = {2'b0, rhs_pix} << sh;
  assign rhs_cl     = (rhs_bytes > 11'd512) ? 11'd512 : rhs_bytes;
  assign rhs_bursts = BW'((rhs_cl + 11'(BB - 1)) >> BBS);
  assign across     = (TW+1)'(tiles_whole) + (TW+1)'(rhs_bursts != '0);
  assign seg_bursts = (tcol < (TW+1)'(tiles_whole)) ? BW'(RB) : rhs_bursts;

  logic [IW-1:0] tile_idx;
  logic [LW-1:0] lane;
  logic [AW-1:0] tbl_word, data_addr;
  assign tile_idx  = IW'(line[HW-1:7]) * IW'(across) + IW'(tcol);
  assign lane      = tile_idx[LW-1:0];
  assign tbl_word  = {tbl_base, 9'h0} + ((AW'(tile_idx) << 1) & ~AW'(DW/8 - 1));
  assign data_addr = AW'({entry, 16'h0}) + AW'({line[6:0], 9'h0}) + (AW'(bcnt) << BBS);

  logic quiet, restart, room, fire, push, pop;
  assign quiet     = (state == S_IDLE) || (state == S_TREQ) || (state == S_DREQ);
  assign restart   = (pend || frame_start) && quiet;
  assign room      = count <= CW'(FIFO_DEPTH - BEATS);
  assign req_valid = !restart && ((state == S_TREQ) || ((state == S_DREQ) && room));
  assign req_addr  = (state == S_TREQ) ? tbl_word : data_addr;
  assign req_len   = (state == S_TREQ) ? LENW'(1) : LENW'(BEATS);
  assign fire      = req_valid && req_ready;

  logic [BW-1:0] nb;
  logic [TW:0]   nt;
  logic [HW-1:0] nl;
  assign nb = bcnt + BW'(1);
  assign nt = tcol + (TW+1)'(1);
  assign nl = line + HW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; dma_on <= 1'b0; pend <= 1'b0;
      line <= '0; tcol <= '0; bcnt <= '0; bt <= '0; entry <= '0;
    end else if (restart) begin
      pend   <= 1'b0;
      dma_on <= dma_en;
      line <= '0; tcol <= '0; bcnt <= '0;
      state  <= (dma_en && height != '0 && across != '0) ? S_TREQ : S_IDLE;
    end else begin
      if (frame_start) pend <= 1'b1;
      case (state)
        S_TREQ:  if (fire) state <= S_TWAIT;
        S_TWAIT: if (rsp_valid) begin
          entry <= rsp_data[{lane, 4'b0} +: 16];
          state <= S_DREQ;
        end
        S_DREQ:  if (fire) begin bt <= '0; state <= S_DWAIT; end
        S_DWAIT: if (rsp_valid) begin
          bt <= bt + LENW'(1);
          if (bt == LENW'(BEATS - 1)) begin
            if (nb < seg_bursts) begin
              bcnt <= nb; state <= S_DREQ;
            end else begin
              bcnt <= '0;
              if (nt < across) begin
                tcol <= nt; state <= S_TREQ;
              end else begin
                tcol <= '0;
                if (nl < height) begin line <= nl; state <= S_TREQ; end
                else begin line <= '0; state <= S_IDLE; end
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // pixel FIFO
  assign push      = rsp_valid && (state == S_DWAIT) && !fifo_clr;
  assign pix_valid = count != '0;
  assign pop       = pix_valid && pix_ready && !fifo_clr;
  assign pix_data  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (fifo_clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= wp + FW'(1);
      if (pop)  rp <= rp + FW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) if (push) mem[wp] <= rsp_data;

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count < CW'(FIFO_DEPTH));
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !pix_valid);
  p_enable_at_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on != $past(dma_on)) |-> $past(frame_start || pend));
  p_off_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_on |-> !req_valid);
  p_burst_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == LENW'(BEATS)) |-> req_addr[BBS-1:0] == '0);
endmodule

// File: tb/sim_tile_scan_fetch.sv
`timescale 1ns/1ps
module sim_tile_scan_fetch;
  localparam logic [31:0] TBL_ADDR = 32'h0001_0200;
  // columns: whole, rhs_pix, depth, height, expected requests, sink mode
  localparam int VEC [7][6] = '{
    '{1,   0, 0, 160, 1440, 1},
    '{2, 100, 1, 130, 2990, 1},
    '{1,  40, 2,   4,   52, 0},
    '{0, 511, 0,   3,   27, 0},
    '{1, 300, 2,   2,   36, 1},
    '{3,   0, 0,   0,    0, 0},
    '{0,   0, 1,   5,    0, 0}};

  logic clk = 0, rst_n = 0;
  logic [22:0] tbl_base = 23'(TBL_ADDR >> 9);
  logic [5:0] tiles_whole = 0;
  logic [8:0] rhs_pix = 0;
  logic [1:0] depth = 0;
  logic [11:0] height = 0;
  logic dma_en = 0, fifo_clr = 0, frame_start = 0;
  logic dma_on, req_valid, req_ready = 1, rsp_valid = 0, pix_valid, pix_ready = 0;
  logic [31:0] req_addr;
  logic [3:0] req_len;
  logic [63:0] rsp_data = 0, pix_data;

  always #10 clk = ~clk;

  tile_scan_fetch u0 (.clk, .rst_n, .tbl_base, .tiles_whole, .rhs_pix, .depth, .height,
    .dma_en, .fifo_clr, .frame_start, .dma_on, .req_valid, .req_ready, .req_addr,
    .req_len, .rsp_valid, .rsp_data, .pix_valid, .pix_ready, .pix_data);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] tbl [64];
  logic [31:0] log_addr [4096];
  int log_len [4096];
  int n_log = 0;
  logic [31:0] exp_addr [4096];
  int exp_len [4096];
  int n_exp = 0;
  logic [31:0] exp_daddr [4096];
  int n_dexp = 0;
  int rem = 0, cyc = 0, n_pix = 0, pix_bad = 0, pix_mode = 0;
  bit is_tbl = 0, bubble_en = 1, pix_chk_en = 0;
  logic [31:0] cur_addr = 0;
  logic [63:0] bad_act = 0, bad_exp = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory model and pixel sink, acting between clock edges
  initial begin
    for (int i = 0; i < 64; i++) tbl[i] = 16'h2000 | 16'(((i * 7 + 3) % 64) << 2);
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (rem > 0 && !(bubble_en && cyc % 7 == 3)) begin
        rsp_valid = 1;
        if (is_tbl) begin
          int w;
          w = int'((cur_addr - TBL_ADDR) >> 3) % 16;
          rsp_data = {tbl[4*w+3], tbl[4*w+2], tbl[4*w+1], tbl[4*w]};
        end else begin
          rsp_data = {~cur_addr, cur_addr};
          cur_addr = cur_addr + 8;
        end
        rem--;
      end else rsp_valid = 0;
      if (req_valid && req_ready) begin
        if (n_log < 4096) begin log_addr[n_log] = req_addr; log_len[n_log] = int'(req_len); end
        n_log++;
        is_tbl = (req_len == 1);
        cur_addr = req_addr;
        rem = int'(req_len);
      end
      pix_ready = (pix_mode == 0) ? 1'b1 : (pix_mode == 1) ? (cyc % 5 != 0) : 1'b0;
      if (pix_valid && pix_ready && !fifo_clr) begin
        if (pix_chk_en && n_pix < n_dexp * 8) begin
          logic [31:0] a;
          a = exp_daddr[n_pix >> 3] + 32'((n_pix & 7) * 8);
          if (pix_data !== {~a, a}) begin
            if (pix_bad == 0) begin bad_act = pix_data; bad_exp = {~a, a}; end
            pix_bad++;
          end
        end
        n_pix++;
      end
    end
  end

  task automatic build_exp(input int whole, input int rhs, input int dep, input int hgt);
    int bytes, pb, across;
    n_exp = 0; n_dexp = 0;
    bytes = rhs << ((dep > 1) ? 2 : dep);
    if (bytes > 512) bytes = 512;
    pb = (bytes + 63) / 64;
    across = whole + ((pb != 0) ? 1 : 0);
    for (int l = 0; l < hgt; l++)
      for (int c = 0; c < across; c++) begin
        int idx;
        idx = (l / 128) * across + c;
        exp_addr[n_exp] = (TBL_ADDR + 32'(idx * 2)) & ~32'h7; exp_len[n_exp] = 1; n_exp++;
        for (int b = 0; b < ((c < whole) ? 8 : pb); b++) begin
          exp_addr[n_exp] = {tbl[idx % 64], 16'h0} + 32'((l % 128) * 512 + b * 64);
          exp_len[n_exp] = 8;
          exp_daddr[n_dexp] = exp_addr[n_exp];
          n_exp++; n_dexp++;
        end
      end
  endtask

  task automatic set_cfg(input int whole, input int rhs, input int dep, input int hgt);
    tiles_whole = 6'(whole); rhs_pix = 9'(rhs); depth = 2'(dep); height = 12'(hgt);
  endtask

  task automatic pulse_frame();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic wait_frame(input int nreq, input int npix);
    int t;
    t = 0;
    while ((n_log < nreq || rem != 0 || n_pix < npix) && t < 60000) begin
      @(negedge clk); t++;
    end
    repeat (30) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(dma_on == 0 && req_valid == 0 && pix_valid == 0, "R1", "outputs in reset",
        {dma_on, req_valid, pix_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(dma_on == 0 && req_valid == 0 && pix_valid == 0, "R1", "outputs after reset",
        {dma_on, req_valid, pix_valid}, 0);

    // vector table: one frame each
    for (int v = 0; v < 7; v++) begin
      int bt, bd, fi;
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      build_exp(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      pix_mode = VEC[v][5]; pix_chk_en = 1; bubble_en = 1;
      n_log = 0; n_pix = 0; pix_bad = 0;
      dma_en = 1;
      pulse_frame();
      chk(dma_on == 1, "R2", $sformatf("vec %0d enable at frame start", v), dma_on, 1);
      wait_frame(VEC[v][4], n_dexp * 8);
      chk(n_log == VEC[v][4], "R10", $sformatf("vec %0d request count, none after end", v),
          n_log, VEC[v][4]);
      bt = 0; bd = 0; fi = -1;
      for (int i = 0; i < n_exp && i < n_log; i++)
        if (log_addr[i] !== exp_addr[i] || log_len[i] != exp_len[i]) begin
          if (fi < 0) fi = i;
          if (exp_len[i] == 1) bt++; else bd++;
        end
      chk(bt == 0, "R3", $sformatf("vec %0d table reads (first bad %0d)", v, fi),
          (fi >= 0) ? log_addr[fi] : 0, (fi >= 0) ? exp_addr[fi] : 0);
      chk(bd == 0, "R4 R5 R6", $sformatf("vec %0d burst order (first bad %0d)", v, fi),
          (fi >= 0) ? log_addr[fi] : 0, (fi >= 0) ? exp_addr[fi] : 0);
      chk(n_pix == n_dexp * 8 && pix_bad == 0, "R7 R8", $sformatf("vec %0d pixel words", v),
          (pix_bad != 0) ? bad_act : 64'(n_pix), (pix_bad != 0) ? bad_exp : 64'(n_dexp * 8));
    end

    // R7: stalled sink limits outstanding data to the FIFO size
    set_cfg(0, 511, 0, 3); build_exp(0, 511, 0, 3);
    pix_mode = 2; n_log = 0; n_pix = 0; pix_bad = 0;
    pulse_frame();
    repeat (200) @(negedge clk);
    chk(n_log == 5, "R7", "requests with stalled sink", n_log, 5);
    pix_mode = 0;
    wait_frame(27, n_dexp * 8);
    chk(n_log == 27 && pix_bad == 0, "R7 R8", "frame completes after stall", n_log, 27);

    // R2: enable change alone is ignored; applied at frame start
    dma_en = 0; n_log = 0;
    repeat (10) @(negedge clk);
    chk(dma_on == 1, "R2", "disable without frame start", dma_on, 1);
    pulse_frame();
    chk(dma_on == 0, "R2", "disable at frame start", dma_on, 0);
    dma_en = 1;
    repeat (40) @(negedge clk);
    chk(dma_on == 0 && n_log == 0, "R2", "no requests while off", n_log, 0);

    // R11: frame start during a data burst
    set_cfg(1, 0, 0, 160); pix_chk_en = 0; bubble_en = 0; n_log = 0;
    pulse_frame();
    while (!(n_log >= 5 && !is_tbl && rem >= 3)) @(negedge clk);
    k = n_log;
    pulse_frame();
    while (n_log < k + 2) @(negedge clk);
    chk(log_addr[k] == (TBL_ADDR & ~32'h7) && log_len[k] == 1, "R11",
        "first request after deferred frame start", log_addr[k], TBL_ADDR & ~32'h7);
    chk(log_addr[k+1] == {tbl[0], 16'h0} && log_len[k+1] == 8, "R10 R11",
        "restart at row 0 tile 0", log_addr[k+1], {tbl[0], 16'h0});

    // R9: clear meets a returning beat and a pop in the same cycle
    pix_mode = 2;
    while (!(pix_valid && !is_tbl && rem >= 4)) @(negedge clk);
    pix_mode = 0;
    fifo_clr = 1;
    @(negedge clk);
    fifo_clr = 0;
    #2;
    chk(pix_valid == 0, "R9", "FIFO empty after clear", pix_valid, 0);
    @(negedge clk); #2;
    chk(pix_valid == 1, "R9", "beat after clear accepted", pix_valid, 1);

    dma_en = 0;
    pulse_frame();
    repeat (40) @(negedge clk);
    chk(dma_on == 0 && req_valid == 0, "R2 R10", "stopped after disable frame",
        {dma_on, req_valid}, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule